// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block models one programmable logic cell of a sum-of-products fabric. Eighteen literals (sixteen from a routing bus, two from dedicated pins) feed an array of twenty product terms; every term can take each literal in true form, complemented form, or not at all, as set by two configuration bitmaps. The terms fall into four OR groups of unequal size. Every cell output picks any mix of those groups, so wide functions can be built by merging groups, or it can instead take a fast four-term path of its own.

Each output ends in an XOR stage feeding a D register. The XOR second operand is either a dedicated product term (logic use) or the register's own state (toggle use, which together with feedback terms gives T and J-K behaviour). The register can be skipped for a combinational result. Three control functions borrow product terms: a local clock, a local reset and an output enable. Any term taken for control is dropped from the logic sums. The configuration is presented as static packed port vectors. The cell outputs go back to the routing bus outside this block.

Registers run on one block clock. The clock choice is a capture strobe: one of three global tick inputs, or the rising edge of the local clock term as seen at the clock edge.

Top module: `ptermCell`

## Requirements
- R1: Product term t is the AND of every literal whose bit is set in `cfgTrue[t*18+i]` (true form) or `cfgComp[t*18+i]` (complemented form). Literal i is `busIn[i]` for i 0 to 15 and `dedIn[i-16]` for 16 and 17. A term with no literal selected is 0.
- R2: The terms form groups G0 = terms 0-3, G1 = 4-7, G2 = 8-12, G3 = 13-19. The OR result of output o is the OR of every group g whose bit `cfgGroupSel[o*4+g]` is set, so groups may be merged (for example G3 with G0 gives 11 terms).
- R3: With `cfgBypass[o]` set, output o is combinationally the OR of terms 4o to 4o+3, regardless of the register, the XOR mode and the register-skip bit.
- R4: With `cfgBypass[o]` clear and `cfgRegBypass[o]` set, output o is combinationally the XOR-stage result; otherwise it is the register state.
- R5: `cfgXorMode[2o+1:2o]` = 1 makes the XOR-stage result the OR result XOR term 16+o; codes 0 and 3 pass the OR result unchanged.
- R6: `cfgXorMode[2o+1:2o]` = 2 makes the XOR-stage result the OR result XOR the register state, so a set OR result toggles the register at each capture.
- R7: With `cfgClkSel` = k for k 0 to 2, registers load their XOR-stage result at a clock edge only when `gTick[k]` is 1 at that edge; the other ticks are ignored.
- R8: With `cfgClkSel` = 3, registers load at a clock edge only when term 12 is 1 at that edge and was 0 at the previous edge.
- R9: `rstN` low clears all registers at once. `cfgRstSel` = 1 (term 12) or 2 (term 19) chooses a local reset term; when that term is 1 at a clock edge all registers are 0 after that edge and stay 0 until an edge at which the term is 0 has passed. Codes 0 and 3 disable the local reset.
- R10: `oeOut` equals term 19 when `cfgOeEn` is 1 and is 0 otherwise.
- R11: Term 12 is removed from all logic sums when `cfgClkSel` = 3 or `cfgRstSel` = 1; term 19 is removed when `cfgOeEn` = 1 or `cfgRstSel` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Global reset, active low, asynchronous |
| gTick | input | 3 | Global clock strobes, one per selectable clock |
| busIn | input | 16 | Routing bus literals 0 to 15 |
| dedIn | input | 2 | Dedicated literals 16 and 17 |
| cfgTrue | input | 360 | True-form literal selection, 18 bits per term |
| cfgComp | input | 360 | Complemented-form literal selection, 18 bits per term |
| cfgGroupSel | input | 16 | Per-output OR-group selection, 4 bits per output |
| cfgBypass | input | 4 | Per-output four-term fast path select |
| cfgRegBypass | input | 4 | Per-output register skip |
| cfgXorMode | input | 8 | Per-output XOR operand code, 2 bits per output |
| cfgClkSel | input | 2 | Capture source: global tick 0 to 2, or 3 for local term |
| cfgRstSel | input | 2 | Local reset term select |
| cfgOeEn | input | 1 | Use term 19 as output enable |
| cellOut | output | 4 | Cell outputs |
| oeOut | output | 1 | Output enable term |

## Verification
Random sparse term programs (one or two literals per term) drive random literal vectors so each term is true often enough for group merging, the fast path and the XOR operands to be told apart from one another. Toggle mode is run with the capture strobe held high, which separates a toggling register from one that merely reloads its sum. Random tick patterns under each clock choice expose a register that loads on the wrong strobe, and a single-literal local clock term produces both rising and steady cycles. A single-literal local reset term and a mid-cycle global reset distinguish registered from immediate clearing.

// File: rtl/ptermPkg.sv
package ptermPkg;
  localparam int NUM_BUS   = 16;
  localparam int NUM_DED   = 2;
  localparam int NUM_IN    = NUM_BUS + NUM_DED;
  localparam int NUM_TERMS = 20;
  localparam int NUM_OUT   = 4;
  localparam int NUM_GRP   = 4;
  localparam int NUM_GCLK  = 3;
  localparam int CLK_TERM  = 12;
  localparam int OE_TERM   = 19;
  localparam int BP_WIDTH  = 4;
  localparam int XOR_BASE  = 16;
  localparam int CLK_SEL_W = $clog2(NUM_GCLK + 1);

  // Unequal OR groups: 4, 4, 5 and 7 terms.
  function automatic int grpLo(input int g);
    case (g)
      0: return 0;
      1: return 4;
      2: return 8;
      default: return 13;
    endcase
  endfunction

  function automatic int grpHi(input int g);
    case (g)
      0: return 3;
      1: return 7;
      2: return 12;
      default: return 19;
    endcase
  endfunction

  typedef enum logic [1:0] {
    XOR_OFF     = 2'd0,
    XOR_TERM    = 2'd1,
    XOR_TOGGLE  = 2'd2,
    XOR_OFF_ALT = 2'd3
  } xorMode_e;

  typedef enum logic [1:0] {
    RST_NONE     = 2'd0,
    RST_CLKTERM  = 2'd1,
    RST_OETERM   = 2'd2,
    RST_NONE_ALT = 2'd3
  } rstSel_e;

  typedef struct packed {
    logic                 capture;
    logic                 clearN;
    logic                 rstReq;
    logic [NUM_TERMS-1:0] ctrlMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptermAndArray.sv
module ptermAndArray #(
  parameter int N_IN    = ptermPkg::NUM_IN,
  parameter int N_TERMS = ptermPkg::NUM_TERMS
) (
  input  logic [N_IN-1:0]         lit,
  input  logic [N_TERMS*N_IN-1:0] cfgTrue,
  input  logic [N_TERMS*N_IN-1:0] cfgComp,
  output logic [N_TERMS-1:0]      term
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_IN-1:0] tSel;
    logic [N_IN-1:0] cSel;
    logic            anyLit;
    logic            allMet;
    assign tSel   = cfgTrue[t*N_IN +: N_IN];
    assign cSel   = cfgComp[t*N_IN +: N_IN];
    assign anyLit = |(tSel | cSel);
    // R1: each selected literal must match its polarity.
    assign allMet = &((lit | ~tSel) & (~lit | ~cSel));
    assign term[t] = anyLit & allMet;
  end
endmodule

// File: rtl/ptermControl.sv
module ptermControl
  import ptermPkg::*;
#(
  parameter int N_GCLK  = NUM_GCLK,
  parameter int N_TERMS = NUM_TERMS,
  parameter int SEL_W   = CLK_SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_GCLK-1:0]  gTick,
  input  logic [N_TERMS-1:0] term,
  input  logic [SEL_W-1:0]   cfgClkSel,
  input  logic [1:0]         cfgRstSel,
  input  logic               cfgOeEn,
  output ctrlStrobe_t        st,
  output logic               oeOut
);
  logic    globalTick;
  logic    localMode;
  logic    clkTermPrev;
  logic    rstReq;
  logic    rstQ;
  rstSel_e rstSel;

  assign rstSel    = rstSel_e'(cfgRstSel);
  assign localMode = (cfgClkSel == SEL_W'(N_GCLK));

  always_comb begin
    globalTick = 1'b0;
    for (int k = 0; k < N_GCLK; k++) begin
      if (cfgClkSel == SEL_W'(k)) globalTick = gTick[k];
    end
  end

  // Local clock term seen at each edge; used for edge detection only.
  always_ff @(posedge clk) clkTermPrev <= term[CLK_TERM];

  always_comb begin
    case (rstSel)
      RST_CLKTERM: rstReq = term[CLK_TERM];
      RST_OETERM:  rstReq = term[OE_TERM];
      default:     rstReq = 1'b0;
    endcase
  end

  // Local reset is registered so the combined clear is a single clean OR.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstQ <= 1'b0;
    else       rstQ <= rstReq;
  end

  always_comb begin
    st.capture  = localMode ? (term[CLK_TERM] & ~clkTermPrev) : globalTick;
    st.clearN   = rstN & ~rstQ;
    st.rstReq   = rstReq;
    st.ctrlMask = '0;
    st.ctrlMask[CLK_TERM] = localMode | (rstSel == RST_CLKTERM);
    st.ctrlMask[OE_TERM]  = cfgOeEn | (rstSel == RST_OETERM);
  end

  assign oeOut = cfgOeEn & term[OE_TERM];

  // R8: a local capture only happens on a rising clock term.
  p_local_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (localMode && st.capture) |-> $rose(term[CLK_TERM]));

  // R9: a local reset request clears at the following edge.
  p_local_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.rstReq |=> !st.clearN);
endmodule

// File: rtl/ptermDatapath.sv
module ptermDatapath
  import ptermPkg::*;
#(
  parameter int N_TERMS = NUM_TERMS,
  parameter int N_OUT   = NUM_OUT,
  parameter int N_GRP   = NUM_GRP,
  parameter int BPW     = BP_WIDTH,
  parameter int XB      = XOR_BASE
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [N_TERMS-1:0]     term,
  input  ctrlStrobe_t            st,
  input  logic [N_OUT*N_GRP-1:0] cfgGroupSel,
  input  logic [N_OUT-1:0]       cfgBypass,
  input  logic [N_OUT-1:0]       cfgRegBypass,
  input  logic [2*N_OUT-1:0]     cfgXorMode,
  output logic [N_OUT-1:0]       cellOut
);
  logic [N_TERMS-1:0] logicTerm;
  logic [N_GRP-1:0]   grpSum;
  logic [N_OUT-1:0]   orSum;
  logic [N_OUT-1:0]   bpSum;
  logic [N_OUT-1:0]   xorOp;
  logic [N_OUT-1:0]   dVal;
  logic [N_OUT-1:0]   q;
  logic               clearN;

  // R11: terms taken for control never reach the sums.
  assign logicTerm = term & ~st.ctrlMask;
  assign clearN    = st.clearN;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = grpLo(g);
    localparam int HI = grpHi(g);
    assign grpSum[g] = |logicTerm[HI:LO];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    xorMode_e mode;
    logic     xb;
    assign mode     = xorMode_e'(cfgXorMode[2*o +: 2]);
    assign orSum[o] = |(grpSum & cfgGroupSel[o*N_GRP +: N_GRP]);
    assign bpSum[o] = |logicTerm[o*BPW +: BPW];

    always_comb begin
      case (mode)
        XOR_TERM:   xb = logicTerm[XB + o];
        XOR_TOGGLE: xb = q[o];
        default:    xb = 1'b0;
      endcase
    end

    assign xorOp[o]   = xb;
    assign dVal[o]    = orSum[o] ^ xorOp[o];
    assign cellOut[o] = cfgBypass[o]    ? bpSum[o] :
                        cfgRegBypass[o] ? dVal[o]  : q[o];

    // R6: toggle mode flips the state whenever the sum is set at a capture.
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
      (mode == XOR_TOGGLE && st.capture && st.clearN && !st.rstReq && orSum[o])
      |=> (q[o] != $past(q[o])));
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN)         q <= '0;
    else if (st.capture) q <= dVal;
  end

  // R9: while the clear is active the state is empty.
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !st.clearN |-> (q == '0));

  // R7: without a capture strobe the state holds.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!st.capture && st.clearN && !st.rstReq) |=> $stable(q));
endmodule

// File: rtl/ptermCell.sv
module ptermCell
  import ptermPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_GCLK-1:0]           gTick,
  input  logic [NUM_BUS-1:0]            busIn,
  input  logic [NUM_DED-1:0]            dedIn,
  input  logic [NUM_TERMS*NUM_IN-1:0]   cfgTrue,
  input  logic [NUM_TERMS*NUM_IN-1:0]   cfgComp,
  input  logic [NUM_OUT*NUM_GRP-1:0]    cfgGroupSel,
  input  logic [NUM_OUT-1:0]            cfgBypass,
  input  logic [NUM_OUT-1:0]            cfgRegBypass,
  input  logic [2*NUM_OUT-1:0]          cfgXorMode,
  input  logic [CLK_SEL_W-1:0]          cfgClkSel,
  input  logic [1:0]                    cfgRstSel,
  input  logic                          cfgOeEn,
  output logic [NUM_OUT-1:0]            cellOut,
  output logic                          oeOut
);
  logic [NUM_IN-1:0]    lit;
  logic [NUM_TERMS-1:0] term;
  ctrlStrobe_t          st;

  assign lit = {dedIn, busIn};

  ptermAndArray #(.N_IN(NUM_IN), .N_TERMS(NUM_TERMS)) andArray_i (
    .lit     (lit),
    .cfgTrue (cfgTrue),
    .cfgComp (cfgComp),
    .term    (term)
  );

  ptermControl #(.N_GCLK(NUM_GCLK), .N_TERMS(NUM_TERMS), .SEL_W(CLK_SEL_W)) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .gTick     (gTick),
    .term      (term),
    .cfgClkSel (cfgClkSel),
    .cfgRstSel (cfgRstSel),
    .cfgOeEn   (cfgOeEn),
    .st        (st),
    .oeOut     (oeOut)
  );

  ptermDatapath #(.N_TERMS(NUM_TERMS), .N_OUT(NUM_OUT), .N_GRP(NUM_GRP),
                  .BPW(BP_WIDTH), .XB(XOR_BASE)) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .term         (term),
    .st           (st),
    .cfgGroupSel  (cfgGroupSel),
    .cfgBypass    (cfgBypass),
    .cfgRegBypass (cfgRegBypass),
    .cfgXorMode   (cfgXorMode),
    .cellOut      (cellOut)
  );
endmodule

// File: tb/ptermCell_tb_top.sv
module ptermCell_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic [2:0]   gTick;
  logic [15:0]  busIn;
  logic [1:0]   dedIn;
  logic [359:0] cfgTrue;
  logic [359:0] cfgComp;
  logic [15:0]  cfgGroupSel;
  logic [3:0]   cfgBypass;
  logic [3:0]   cfgRegBypass;
  logic [7:0]   cfgXorMode;
  logic [1:0]   cfgClkSel;
  logic [1:0]   cfgRstSel;
  logic         cfgOeEn;
  logic [3:0]   cellOut;
  logic         oeOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  randTick = 1'b1;

  always #10 clk = ~clk;

  ptermCell dut_i (
    .clk(clk), .rstN(rstN), .gTick(gTick), .busIn(busIn), .dedIn(dedIn),
    .cfgTrue(cfgTrue), .cfgComp(cfgComp), .cfgGroupSel(cfgGroupSel),
    .cfgBypass(cfgBypass), .cfgRegBypass(cfgRegBypass), .cfgXorMode(cfgXorMode),
    .cfgClkSel(cfgClkSel), .cfgRstSel(cfgRstSel), .cfgOeEn(cfgOeEn),
    .cellOut(cellOut), .oeOut(oeOut)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic logic [19:0] refTerms(input logic [17:0] lit,
                                           input logic [359:0] tr, input logic [359:0] cp);
    logic [19:0] r;
    for (int t = 0; t < 20; t++) begin
      logic any = 1'b0;
      logic v   = 1'b1;
      for (int i = 0; i < 18; i++) begin
        if (tr[t*18+i]) begin any = 1'b1; v = v & lit[i];  end
        if (cp[t*18+i]) begin any = 1'b1; v = v & ~lit[i]; end
      end
      r[t] = any & v;
    end
    return r;
  endfunction

  function automatic logic [19:0] refMask(input logic [1:0] cs, input logic [1:0] rs, input logic oe);
    logic [19:0] m = '0;
    m[12] = (cs == 2'd3) || (rs == 2'd1);
    m[19] = oe || (rs == 2'd2);
    return m;
  endfunction

  function automatic logic refOr(input int o, input logic [19:0] lt, input logic [15:0] gs);
    logic r = 1'b0;
    if (gs[o*4+0]) r = r | (|lt[3:0]);
    if (gs[o*4+1]) r = r | (|lt[7:4]);
    if (gs[o*4+2]) r = r | (|lt[12:8]);
    if (gs[o*4+3]) r = r | (|lt[19:13]);
    return r;
  endfunction

  function automatic logic refD(input int o, input logic [19:0] lt, input logic qv,
                                input logic [15:0] gs, input logic [7:0] xm);
    logic s = refOr(o, lt, gs);
    case (xm[2*o +: 2])
      2'd1:    return s ^ lt[16+o];
      2'd2:    return s ^ qv;
      default: return s;
    endcase
  endfunction

  logic [19:0] curTerms;
  logic [19:0] curLogic;
  logic [3:0]  modelQ;
  logic        modelRstQ;
  logic        prev12;

  assign curTerms = refTerms({dedIn, busIn}, cfgTrue, cfgComp);
  assign curLogic = curTerms & ~refMask(cfgClkSel, cfgRstSel, cfgOeEn);

  always @(posedge clk) prev12 <= curTerms[12];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelQ    <= '0;
      modelRstQ <= 1'b0;
    end else begin
      logic       rq;
      logic       cap;
      logic [3:0] d;
      rq  = (cfgRstSel == 2'd1) ? curTerms[12] : (cfgRstSel == 2'd2) ? curTerms[19] : 1'b0;
      cap = (cfgClkSel == 2'd3) ? (curTerms[12] & ~prev12) : gTick[cfgClkSel];
      for (int o = 0; o < 4; o++) d[o] = refD(o, curLogic, modelQ[o], cfgGroupSel, cfgXorMode);
      modelRstQ <= rq;
      modelQ    <= (modelRstQ || rq) ? 4'd0 : (cap ? d : modelQ);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req);
    logic [3:0] expOut;
    logic       expOe;
    for (int o = 0; o < 4; o++) begin
      if (cfgBypass[o])         expOut[o] = |curLogic[o*4 +: 4];
      else if (cfgRegBypass[o]) expOut[o] = refD(o, curLogic, modelQ[o], cfgGroupSel, cfgXorMode);
      else                      expOut[o] = modelQ[o];
    end
    expOe = cfgOeEn & curTerms[19];
    nChecks++;
    if (cellOut !== expOut || oeOut !== expOe) begin
      nFails++;
      $display("FAIL %s: cellOut=%b oeOut=%b expected cellOut=%b oeOut=%b",
               req, cellOut, oeOut, expOut, expOe);
    end
  endtask

  task automatic cyc(input string req);
    @(negedge clk);
    busIn = 16'($urandom);
    dedIn = 2'($urandom);
    if (randTick) gTick = 3'($urandom);
    #1 chk(req);
    @(posedge clk);
    #1 chk(req);
  endtask

  task automatic randCfg();
    cfgTrue = '0;
    cfgComp = '0;
    for (int t = 0; t < 20; t++) begin
      int n = 1 + int'($urandom % 2);
      for (int k = 0; k < n; k++) begin
        int i = int'($urandom % 18);
        if ($urandom % 2 == 0) cfgTrue[t*18+i] = 1'b1;
        else                   cfgComp[t*18+i] = 1'b1;
      end
    end
    cfgGroupSel  = 16'($urandom);
    cfgBypass    = '0;
    cfgRegBypass = '0;
    cfgXorMode   = '0;
    cfgClkSel    = '0;
    cfgRstSel    = '0;
    cfgOeEn      = 1'b0;
    randTick     = 1'b1;
  endtask

  task automatic setSingle(input int t, input int i);
    for (int k = 0; k < 18; k++) begin
      cfgTrue[t*18+k] = 1'b0;
      cfgComp[t*18+k] = 1'b0;
    end
    cfgTrue[t*18+i] = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    randCfg();
    gTick = 3'b111;
    busIn = 16'hFFFF;
    dedIn = 2'b11;
    rstN  = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R9 reset state");
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic tSop();
    randCfg();
    cfgRegBypass = 4'hF;
    for (int n = 0; n < 30; n++) begin
      if (n % 10 == 0) cfgGroupSel = 16'($urandom);
      cyc("R1 R2 R4 sum of products");
    end
    // Empty group: terms 0-3 unprogrammed, output 0 uses G0 only.
    cfgTrue[71:0] = '0;
    cfgComp[71:0] = '0;
    cfgGroupSel[3:0] = 4'b0001;
    for (int n = 0; n < 5; n++) cyc("R1 empty terms");
    // Merged G3 with G0 on output 0.
    randCfg();
    cfgRegBypass = 4'hF;
    cfgGroupSel[3:0] = 4'b1001;
    for (int n = 0; n < 10; n++) cyc("R2 merged groups");
  endtask

  task automatic tBypass();
    randCfg();
    for (int n = 0; n < 24; n++) begin
      if (n % 6 == 0) begin
        cfgBypass    = 4'($urandom);
        cfgRegBypass = 4'($urandom);
        cfgXorMode   = 8'($urandom);
      end
      cyc("R3 fast path");
    end
  endtask

  task automatic tXorTerm();
    randCfg();
    cfgRegBypass = 4'hF;
    cfgXorMode   = 8'h55;
    for (int n = 0; n < 20; n++) cyc("R5 R4 xor term");
    cfgXorMode = 8'hFF;
    for (int n = 0; n < 6; n++) cyc("R5 code 3 passes sum");
  endtask

  task automatic tToggle();
    randCfg();
    cfgXorMode = 8'hAA;
    randTick   = 1'b0;
    gTick      = 3'b001;
    for (int n = 0; n < 24; n++) cyc("R6 toggle");
    cfgRegBypass = 4'hF;
    for (int n = 0; n < 6; n++) cyc("R6 R4 toggle comb");
  endtask

  task automatic tGlobalClk();
    for (int k = 0; k < 3; k++) begin
      randCfg();
      cfgClkSel = 2'(k);
      for (int n = 0; n < 16; n++) cyc("R7 global tick select");
    end
  endtask

  task automatic tLocalClk();
    randCfg();
    cfgClkSel = 2'd3;
    setSingle(12, 15);
    for (int n = 0; n < 30; n++) cyc("R8 R11 local clock term");
  endtask

  task automatic tLocalRst();
    randCfg();
    cfgRstSel = 2'd2;
    setSingle(19, 17);
    for (int n = 0; n < 30; n++) cyc("R9 R11 local reset term 19");
    randCfg();
    cfgRstSel = 2'd1;
    setSingle(12, 3);
    for (int n = 0; n < 20; n++) cyc("R9 R11 local reset term 12");
    // Global reset mid-cycle clears at once.
    randCfg();
    randTick = 1'b0;
    gTick    = 3'b001;
    for (int n = 0; n < 6; n++) cyc("R9 load before reset");
    @(negedge clk);
    #3 rstN = 1'b0;
    #1 begin
      nChecks++;
      if (cellOut !== 4'd0) begin
        nFails++;
        $display("FAIL R9 async clear: cellOut=%b expected cellOut=0000", cellOut);
      end
    end
    chk("R9 async clear model");
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic tOe();
    randCfg();
    cfgOeEn = 1'b1;
    cfgRegBypass = 4'hF;
    setSingle(19, 16);
    for (int n = 0; n < 16; n++) cyc("R10 R11 output enable on");
    cfgOeEn = 1'b0;
    for (int n = 0; n < 8; n++) cyc("R10 output enable off");
  endtask

  // ---------------- sequencing ----------------
  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    gTick = '0;
    busIn = '0;
    dedIn = '0;
    randCfg();
    tReset();
    tSop();
    tBypass();
    tXorTerm();
    tToggle();
    tGlobalClk();
    tLocalClk();
    tLocalRst();
    tOe();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    nFails++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule